// File: doc/BRIEF.md
# RTC periodic pulse and interrupt output

This block drives the periodic output pin of a real-time clock. The timekeeping chain supplies several strobes: a 128 Hz tick, plus one-cycle carry strobes from the 64 Hz prescaler stage and from the seconds, minutes and hours digits. A two-bit period select picks which of these carries starts an output event, so every event is aligned with a clock-digit carry. The block has no divider of its own for the period.

The output is open-drain. It is modelled as an active-high pull-low enable. Two modes are available:

- **Interrupt mode:** the pin pulls low on each event. It is released either when software writes the flag clear or by automatic return.
- **Standard-pulse mode:** the pin produces a fixed-period waveform whose low time is one 128 Hz tick period (7.8125 ms).

A mask bit keeps the pin released. A readable IRQ flag records each unmasked event until software clears it. All state lives on one system clock, and that clock is qualified by the strobes.

Top module: `rtcp_pulse_out`

## Requirements
- R1: The period select chooses the event strobe: 00 uses `carry_64hz`, 01 uses `carry_sec`, 10 uses `carry_min` and 11 uses `carry_hour`. A strobe that is not selected never starts an event.
- R2: A selected strobe while `cfg_mask` is 0, in a cycle with no configuration change, sets `pin_pull_low` and `irq_flag` to 1 from the next clock.
- R3: An active pulse ends by itself. `pin_pull_low` returns to 0 on the clock that samples the PULSE_TICKS-th `tick_128` after the event cycle. A tick in the event cycle itself is not counted. The default of 1 tick gives 7.8125 ms.
- R4: While `cfg_mask` is 1, events neither pull the pin low nor set the flag. Raising the mask during a pulse releases the pin on the next clock.
- R5: In interrupt mode (`cfg_irq_mode` = 1), a `flag_clr` strobe with no event in the same cycle releases the pin on the next clock, before the automatic return.
- R6: In standard-pulse mode (`cfg_irq_mode` = 0), `flag_clr` clears the flag but does not shorten the low pulse.
- R7: The flag stays 1 until `flag_clr`. The clear takes effect on the next clock. An unmasked event in the same cycle as the clear wins, and the flag stays 1.
- R8: A change of `cfg_irq_mode` or `cfg_period` releases the pin on the next clock. The pin stays released until the next selected carry that comes after the change.
- R9: Synchronous active-low reset leaves `pin_pull_low` and `irq_flag` at 0.
- R10: An event during an active pulse restarts the width count, so the pulse ends PULSE_TICKS ticks after the latest event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_128 | input | 1 | One-cycle strobe at 128 Hz |
| carry_64hz | input | 1 | Carry strobe from the 64 Hz prescaler stage |
| carry_sec | input | 1 | Carry strobe into the seconds digit |
| carry_min | input | 1 | Carry strobe into the minutes digit |
| carry_hour | input | 1 | Carry strobe into the hours digit |
| cfg_mask | input | 1 | 1 keeps the pin released and blocks the flag |
| cfg_irq_mode | input | 1 | 1 = interrupt mode, 0 = standard-pulse mode |
| cfg_period | input | 2 | Period select (00 1/64 s, 01 1 s, 10 1 min, 11 1 h) |
| flag_clr | input | 1 | One-cycle strobe: software writes 0 to the flag |
| pin_pull_low | output | 1 | 1 drives the pin low, 0 leaves it open |
| irq_flag | output | 1 | IRQ flag readback |

## Verification
The bench drives the strobes that are not selected and checks that they leave the pin alone. A wrong multiplexer would start pulses at the wrong rate. Three collisions are aimed at directly:

- A tick in the event cycle. A design that counted it would end the pulse at once.
- A clear together with an event. A design with the wrong priority would lose the interrupt.
- A clear in standard mode. Wrongly coupled, it would chop the waveform.

The bench also changes mode and period mid-pulse and raises the mask mid-pulse. A design without those kills would keep the pin low under a stale configuration. Long random stretches compare every cycle against a behavioural model, so a lost restart of the width count or a stuck flag also shows up.

// File: rtl/rtcp_pkg.sv
// Package: shared types for the RTC periodic output block.
// Assumes the period encoding is fixed by the control register layout.
package rtcp_pkg;

    typedef enum logic [1:0] {
        PER_64HZ = 2'b00,
        PER_SEC  = 2'b01,
        PER_MIN  = 2'b10,
        PER_HOUR = 2'b11
    } period_e;

    localparam int NUM_PERIODS = 4;

    typedef struct packed {
        logic    irq_mode;
        period_e period;
    } cfg_t;

endpackage

// File: rtl/rtcp_carry_sel.sv
// Module: picks the carry strobe that starts an output event.
// Assumes the strobes are one system clock wide and that index i of
// carries belongs to period code i.
module rtcp_carry_sel
    import rtcp_pkg::*;
#(
    parameter int NUM_SRC = NUM_PERIODS,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] carries,
    input  logic [SEL_W-1:0]   sel,
    output logic               event_strobe
);

    logic [NUM_SRC-1:0] hit;

    // One-hot decode of the select, gated by each source strobe.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = carries[i] && (sel == SEL_W'(i));
    end

    // At most one source is decoded, so an OR reduction is the multiplexer.
    always_comb begin
        event_strobe = |hit;
    end

    // R1: the decoded selection never enables two sources.
    always_comb begin
        a_r1_onehot_sel: assert ($onehot0(hit));
    end

endmodule

// File: rtl/rtcp_width_timer.sv
// Module: pulse-width timer shared by both output modes.
// It holds the pulse active for PULSE_TICKS ticks counted after the
// start cycle. Assumes tick is a one-cycle strobe. Priority order:
// kill, then start, then release, then counting.
module rtcp_width_timer #(
    parameter int PULSE_TICKS = 1,
    localparam int CNT_W      = $clog2(PULSE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic kill,
    input  logic release_req,
    output logic active
);

    logic [CNT_W-1:0] remaining;

    // Load on start, count ticks while active, and drop on expiry, kill or release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            remaining <= '0;
        end else if (kill) begin
            active    <= 1'b0;
            remaining <= '0;
        end else if (start) begin
            active    <= 1'b1;
            remaining <= CNT_W'(PULSE_TICKS);
        end else if (release_req) begin
            active    <= 1'b0;
            remaining <= '0;
        end else if (tick && active) begin
            if (remaining == CNT_W'(1)) begin
                active    <= 1'b0;
                remaining <= '0;
            end else begin
                remaining <= remaining - CNT_W'(1);
            end
        end
    end

    // R4 and R8: a kill request always releases on the next clock.
    a_r8_kill_releases: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !active);

    // R10: a start without kill leaves the pulse active.
    a_r10_start_active: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !kill) |=> active);

    // R3: the count stays within the programmed width.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= CNT_W'(PULSE_TICKS));

    // R3: an idle timer holds a zero count.
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (remaining == '0));

endmodule

// File: rtl/rtcp_irq_flag.sv
// Module: readable IRQ flag. It is set by an unmasked event and cleared
// by a software strobe. Assumes set has priority over clear.
module rtcp_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);

    // Hold the flag, with set winning over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // R7: a clear alone empties the flag on the next clock.
    a_r7_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !flag);

    // R7: with no request, the flag keeps its value.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !set_req) |=> $stable(flag));

endmodule

// File: rtl/rtcp_cfg_watch.sv
// Module: flags a change of the mode and period bits against the
// previous clock. Assumes the configuration is stable except for writes.
module rtcp_cfg_watch
    import rtcp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    output logic changed
);

    cfg_t cfg_q;

    // Remember the configuration seen on the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{irq_mode: 1'b0, period: PER_64HZ};
        end else begin
            cfg_q <= cfg;
        end
    end

    // Compare the present configuration with the stored copy.
    always_comb begin
        changed = (cfg != cfg_q);
    end

endmodule

// File: rtl/rtcp_pulse_out.sv
// Module: top of the RTC periodic output. It selects the carry for the
// programmed period and runs a shared width timer for both modes. It
// drives the pull-low enable and the IRQ flag. Assumes all strobes are
// one clock wide and synchronous to clk.
module rtcp_pulse_out
    import rtcp_pkg::*;
#(
    parameter int PULSE_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_128,
    input  logic       carry_64hz,
    input  logic       carry_sec,
    input  logic       carry_min,
    input  logic       carry_hour,
    input  logic       cfg_mask,
    input  logic       cfg_irq_mode,
    input  logic [1:0] cfg_period,
    input  logic       flag_clr,
    output logic       pin_pull_low,
    output logic       irq_flag
);

    logic [NUM_PERIODS-1:0] carries;
    logic                   sel_strobe;
    logic                   cfg_changed;
    logic                   start_evt;
    logic                   kill_req;
    logic                   rel_req;
    cfg_t                   cfg_now;

    // Gather the carry strobes in period-code order and pack the config.
    always_comb begin
        carries = {carry_hour, carry_min, carry_sec, carry_64hz};
        cfg_now = '{irq_mode: cfg_irq_mode, period: period_e'(cfg_period)};
    end

    rtcp_carry_sel #(.NUM_SRC(NUM_PERIODS)) u_sel (
        .carries      (carries),
        .sel          (cfg_period),
        .event_strobe (sel_strobe)
    );

    rtcp_cfg_watch u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg_now),
        .changed (cfg_changed)
    );

    // Derive the event and the release requests for the timer.
    always_comb begin
        start_evt = sel_strobe && !cfg_mask;
        kill_req  = cfg_mask || cfg_changed;
        rel_req   = flag_clr && cfg_irq_mode;
    end

    rtcp_width_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_128),
        .start       (start_evt),
        .kill        (kill_req),
        .release_req (rel_req),
        .active      (pin_pull_low)
    );

    rtcp_irq_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (start_evt),
        .clr_req (flag_clr),
        .flag    (irq_flag)
    );

    // R4: the mask keeps the pin open.
    a_r4_mask_open: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mask |=> !pin_pull_low);

    // R4: a masked event never raises the flag.
    a_r4_mask_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask && !irq_flag) |=> !irq_flag);

    // R1: the pin only starts low after a selected carry.
    a_r1_rise_needs_carry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_pull_low) |-> $past(sel_strobe));

    // R2: an unmasked event with a steady config pulls low and flags.
    a_r2_event_out: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && !cfg_mask && !cfg_changed) |=> (pin_pull_low && irq_flag));

    // R5: an interrupt-mode clear without an event releases the pin.
    a_r5_clear_release: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && cfg_irq_mode && !sel_strobe) |=> !pin_pull_low);

    // R6: a standard-mode clear without a tick keeps an active pulse.
    a_r6_clear_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cfg_irq_mode && pin_pull_low && !tick_128 && !cfg_mask
         && !cfg_changed) |=> pin_pull_low);

endmodule

// File: tb/rtcp_pulse_out_bench.sv
// Bench: drives strobes and config, runs a behavioural model and compares on every clock.
module rtcp_pulse_out_bench;

    localparam int CLK_P = 10;
    localparam int PT    = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_128 = 1'b0;
    logic       c64 = 1'b0, csec = 1'b0, cmin = 1'b0, chour = 1'b0;
    logic       cfg_mask = 1'b0, cfg_irq_mode = 1'b0;
    logic [1:0] cfg_period = 2'b00;
    logic       flag_clr = 1'b0;
    logic       pin_pull_low, irq_flag;

    int checks = 0;
    int errors = 0;
    string cur_req = "R9";

    int m_pin = 0, m_flag = 0, m_left = 0, m_prev = 0;

    rtcp_pulse_out #(.PULSE_TICKS(PT)) u_rtcp_pulse_out (
        .clk(clk), .rst_n(rst_n), .tick_128(tick_128),
        .carry_64hz(c64), .carry_sec(csec), .carry_min(cmin), .carry_hour(chour),
        .cfg_mask(cfg_mask), .cfg_irq_mode(cfg_irq_mode), .cfg_period(cfg_period),
        .flag_clr(flag_clr), .pin_pull_low(pin_pull_low), .irq_flag(irq_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural model of the requirements, updated at each clock.
    always @(posedge clk) begin
        int sel, ev, chg, cfgv;
        cfgv = {29'd0, cfg_irq_mode, cfg_period};
        case (cfg_period)
            2'b00: sel = c64;
            2'b01: sel = csec;
            2'b10: sel = cmin;
            default: sel = chour;
        endcase
        if (!rst_n) begin
            m_pin = 0; m_flag = 0; m_left = 0; m_prev = 0;
        end else begin
            chg = (cfgv != m_prev) ? 1 : 0;
            ev  = (sel != 0 && !cfg_mask) ? 1 : 0;
            if (cfg_mask || chg != 0) m_pin = 0;
            else if (ev != 0) begin m_pin = 1; m_left = PT; end
            else if (flag_clr && cfg_irq_mode) m_pin = 0;
            else if (tick_128 && m_pin != 0) begin
                m_left--;
                if (m_left == 0) m_pin = 0;
            end
            if (ev != 0) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_prev = cfgv;
        end
    end

    // Compare the outputs with the model on every clock, away from the edge.
    always @(negedge clk) begin
        chk(cur_req, "pin_pull_low vs model", int'(pin_pull_low), m_pin);
        chk(cur_req, "irq_flag vs model", int'(irq_flag), m_flag);
    end

    // One driven cycle: strobes are set at the negedge and dropped after the posedge.
    task automatic cyc(input logic t, input logic s64, input logic ss,
                       input logic sm, input logic sh, input logic clr);
        @(negedge clk);
        tick_128 = t; c64 = s64; csec = ss; cmin = sm; chour = sh; flag_clr = clr;
        @(posedge clk);
        #1;
        tick_128 = 0; c64 = 0; csec = 0; cmin = 0; chour = 0; flag_clr = 0;
    endtask

    task automatic setcfg(input logic msk, input logic md, input logic [1:0] per);
        @(negedge clk);
        cfg_mask = msk; cfg_irq_mode = md; cfg_period = per;
        @(posedge clk);
        #1;
    endtask

    task automatic look(input string req, input string what, input int pin_e, input int flag_e);
        @(negedge clk);
        #1;
        chk(req, {what, " pin"}, int'(pin_pull_low), pin_e);
        chk(req, {what, " flag"}, int'(irq_flag), flag_e);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog run did not end");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        look("R9", "reset state", 0, 0);
        @(negedge clk); rst_n = 1;
        look("R9", "after reset", 0, 0);

        // R1, R2 and R3 in standard mode, minutes selected
        cur_req = "R1";
        setcfg(0, 0, 2'b10);
        cyc(1, 1, 1, 0, 1, 0);
        look("R1", "unselected strobes", 0, 0);
        cur_req = "R2";
        cyc(1, 0, 0, 1, 0, 0);
        look("R2", "minute carry with tick", 1, 1);
        cur_req = "R3";
        cyc(0, 0, 0, 0, 0, 0);
        look("R3", "no tick holds", 1, 1);
        cyc(1, 0, 0, 0, 0, 0);
        look("R3", "tick ends pulse", 0, 1);

        // R6: a standard-mode clear keeps the pulse
        cur_req = "R6";
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        look("R6", "std clear", 1, 0);
        cyc(1, 0, 0, 0, 0, 0);
        look("R6", "std pulse ends on tick", 0, 0);

        // R10: an event mid-pulse restarts the count
        cur_req = "R10";
        cyc(0, 0, 0, 1, 0, 0);
        cyc(1, 0, 0, 1, 0, 0);
        look("R10", "restart on tick+event", 1, 1);
        cyc(1, 0, 0, 0, 0, 0);
        look("R10", "ends after restart", 0, 1);

        // R5 and R7 in interrupt mode, 1/64 s selected
        cur_req = "R5";
        setcfg(0, 1, 2'b00);
        cyc(0, 1, 0, 0, 0, 0);
        look("R5", "irq event", 1, 1);
        cyc(0, 0, 0, 0, 0, 1);
        look("R5", "irq clear releases", 0, 0);
        cur_req = "R7";
        cyc(0, 1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        look("R7", "auto return keeps flag", 0, 1);
        cyc(0, 1, 0, 0, 0, 1);
        look("R7", "clear+event keeps flag", 1, 1);
        cyc(0, 0, 0, 0, 0, 1);
        look("R7", "clear alone", 0, 0);

        // R8: a config change mid-pulse
        cur_req = "R8";
        cyc(0, 1, 0, 0, 0, 0);
        setcfg(0, 1, 2'b01);
        look("R8", "period change releases", 0, 1);
        cyc(0, 1, 0, 0, 0, 0);
        look("R8", "old strobe no restart", 0, 1);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        setcfg(0, 0, 2'b01);
        look("R8", "mode change releases", 0, 1);

        // R4: masking
        cur_req = "R4";
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 1, 0, 0, 0);
        setcfg(1, 0, 2'b01);
        look("R4", "mask mid-pulse", 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(1, 0, 1, 0, 0, 0);
        look("R4", "masked event", 0, 0);
        setcfg(0, 0, 2'b11);
        cyc(0, 0, 0, 0, 1, 0);
        look("R1", "hour carry selected", 1, 1);

        // Random stretch compared on every clock
        cur_req = "R1";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 63) == 0)
                setcfg($urandom_range(0, 15) == 0, 1'($urandom_range(0, 1)),
                       2'($urandom_range(0, 3)));
            cyc($urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
                $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
                $urandom_range(0, 5) == 0, $urandom_range(0, 11) == 0);
        end
        @(negedge clk);
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule